// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered-clock oscillator runs close enough to its target frequency. The target is either the incoming data rate or a divided-down reference clock, selected by a mode input. Both sources arrive as single-cycle count pulses sampled in the system clock domain. Over a window of a fixed number of target pulses, the block counts oscillator pulses. It then turns the absolute count difference into a pass/fail decision against two error bands.

The block flags loss of lock when the error goes beyond the wide band of 1000 ppm. It clears the flag only once the error has settled inside the narrow band of 250 ppm. An error between the two bands leaves the flag unchanged. A sticky flag records every loss-of-lock event and holds until software pulses a clear bit high and then low. A pin-mode input chooses whether the loss-of-lock pin shows the live status or the sticky flag. A separate output enables the coarse frequency-acquisition loop for as long as live loss of lock is asserted.

Top module: `freq_lock_detector`

## Requirements
- R1: After reset, live loss of lock and `acquire_o` are 1 and `sticky_o` is 0.
- R2: A window whose absolute count error is larger than `WIN_TICKS/1000*ASSERT_PPM/1000` counts sets live loss of lock.
- R3: A window whose absolute count error is at most `WIN_TICKS/1000*DEASSERT_PPM/1000` counts clears live loss of lock.
- R4: A window whose error lies above the deassert band and at or below the assert band leaves live loss of lock unchanged.
- R5: Live loss of lock changes only in the cycle after a window closes. A window closes on the `WIN_TICKS`-th target pulse, and an oscillator pulse in that same cycle counts toward the closing window.
- R6: With `ref_mode_i`=0 the target pulses come from `data_tick_i`, and with `ref_mode_i`=1 they come from `ref_tick_i`. Pulses on the unselected input have no effect.
- R7: A change of `ref_mode_i` discards the window in progress. The cycle in which the change is first seen counts no pulses.
- R8: `sticky_o` goes to 1 in the same cycle that live loss of lock goes from 0 to 1, and it stays 1 after lock is regained.
- R9: `sticky_o` clears only in the cycle after `sticky_clr_i` goes from 1 to 0. While `sticky_clr_i` is held at 1 it does not clear. If a new loss-of-lock event falls in the clearing cycle, the set takes priority over the clear.
- R10: With `pin_sticky_i`=1, `lol_o` equals `sticky_o`. With `pin_sticky_i`=0, `lol_o` shows live loss of lock (1 while acquiring, 0 while locked).
- R11: `acquire_o` equals live loss of lock in both pin modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | Divided oscillator pulse |
| data_tick_i | input | 1 | Data-rate target pulse |
| ref_tick_i | input | 1 | Divided reference target pulse |
| ref_mode_i | input | 1 | 0: target is the data rate, 1: target is the reference |
| pin_sticky_i | input | 1 | 1: `lol_o` shows the sticky flag |
| sticky_clr_i | input | 1 | Sticky clear, takes effect on its falling edge |
| lol_o | output | 1 | Loss-of-lock pin |
| acquire_o | output | 1 | Frequency-acquisition enable |
| sticky_o | output | 1 | Sticky "lock was lost" status |

## Verification
The bench builds the block with `WIN_TICKS`=4000. This gives an assert band of 4 counts and a deassert band of 1 count, so every window takes about 8000 cycles and a full sequence of windows fits in the run. At these values the bench can step the count error exactly to each band edge (1, 3, 4, 5 and the negative side). It drives a target pulse on every other cycle and adds or removes oscillator pulses in chosen pairs. It also floods the unselected target input and abandons a window halfway through a mode switch, so that a leaked count would push the next window far outside the bands.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic {
    SRC_DATA = 1'b0,
    SRC_REF  = 1'b1
  } tgt_src_e;

  // Band width in counts for a window of win ticks; win is a multiple of 1000.
  function automatic int unsigned ppm_to_cnt(int unsigned win, int unsigned ppm);
    return (win / 1000) * ppm / 1000;
  endfunction

endpackage

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int unsigned WIN_TICKS = 100000,
  parameter int unsigned CNT_W     = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tgt_tick_i,
  input  logic             osc_tick_i,
  output logic             done_o,
  output logic [CNT_W-1:0] err_o
);

  localparam int unsigned TGT_W = $clog2(WIN_TICKS);
  localparam logic [TGT_W-1:0] TGT_LAST = TGT_W'(WIN_TICKS - 1);
  localparam logic [CNT_W:0]   WIN_EXT  = (CNT_W+1)'(WIN_TICKS);
  localparam logic [CNT_W-1:0] OSC_MAX  = '1;

  logic [TGT_W-1:0] tgt_cnt_q;
  logic [CNT_W-1:0] osc_cnt_q;
  logic [CNT_W:0]   osc_total;
  logic [CNT_W:0]   abs_diff;
  logic             close_win;

  assign close_win = tgt_tick_i && (tgt_cnt_q == TGT_LAST);
  assign osc_total = {1'b0, osc_cnt_q} + (CNT_W+1)'(osc_tick_i);

  always_comb begin
    if (osc_total >= WIN_EXT) abs_diff = osc_total - WIN_EXT;
    else                      abs_diff = WIN_EXT - osc_total;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_cnt_q <= '0;
      osc_cnt_q <= '0;
      done_o    <= 1'b0;
      err_o     <= '0;
    end else if (restart_i) begin
      tgt_cnt_q <= '0;
      osc_cnt_q <= '0;
      done_o    <= 1'b0;
    end else if (close_win) begin
      tgt_cnt_q <= '0;
      osc_cnt_q <= '0;
      done_o    <= 1'b1;
      err_o     <= abs_diff[CNT_W] ? OSC_MAX : abs_diff[CNT_W-1:0];
    end else begin
      done_o <= 1'b0;
      if (tgt_tick_i) tgt_cnt_q <= tgt_cnt_q + 1'b1;
      if (osc_tick_i && osc_cnt_q != OSC_MAX) osc_cnt_q <= osc_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lockdet_hyst.sv
module lockdet_hyst #(
  parameter int unsigned CNT_W        = 18,
  parameter int unsigned ASSERT_CNT   = 100,
  parameter int unsigned DEASSERT_CNT = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [CNT_W-1:0] err_i,
  output logic             lol_o,
  output logic             lol_set_o
);

  localparam logic [CNT_W-1:0] HI = CNT_W'(ASSERT_CNT);
  localparam logic [CNT_W-1:0] LO = CNT_W'(DEASSERT_CNT);

  logic too_far, close_in;

  assign too_far   = done_i && (err_i > HI);
  assign close_in  = done_i && (err_i <= LO);
  assign lol_set_o = too_far && !lol_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lol_o <= 1'b1;
    else if (too_far)  lol_o <= 1'b1;
    else if (close_in) lol_o <= 1'b0;
  end

endmodule

// File: rtl/lockdet_sticky.sv
module lockdet_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sticky_o,
  output logic clr_q_o
);

  logic clr_fall;

  assign clr_fall = clr_q_o && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q_o  <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      clr_q_o <= clr_i;
      if (set_i)         sticky_o <= 1'b1;
      else if (clr_fall) sticky_o <= 1'b0;
    end
  end

endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector #(
  parameter int unsigned WIN_TICKS    = 100000,
  parameter int unsigned ASSERT_PPM   = 1000,
  parameter int unsigned DEASSERT_PPM = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic data_tick_i,
  input  logic ref_tick_i,
  input  logic ref_mode_i,
  input  logic pin_sticky_i,
  input  logic sticky_clr_i,
  output logic lol_o,
  output logic acquire_o,
  output logic sticky_o
);
  import lockdet_pkg::*;

  localparam int unsigned CNT_W        = $clog2(2 * WIN_TICKS + 1);
  localparam int unsigned ASSERT_CNT   = ppm_to_cnt(WIN_TICKS, ASSERT_PPM);
  localparam int unsigned DEASSERT_CNT = ppm_to_cnt(WIN_TICKS, DEASSERT_PPM);

  tgt_src_e         src_q;
  tgt_src_e         src_d;
  logic             restart;
  logic             tgt_tick;
  logic             win_done;
  logic [CNT_W-1:0] win_err;
  logic             lol_live;
  logic             lol_set;
  logic             clr_q;

  assign src_d    = tgt_src_e'(ref_mode_i);
  assign restart  = (src_d != src_q);
  assign tgt_tick = (src_d == SRC_REF) ? ref_tick_i : data_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_DATA;
    else         src_q <= src_d;
  end

  lockdet_window #(
    .WIN_TICKS (WIN_TICKS),
    .CNT_W     (CNT_W)
  ) i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .tgt_tick_i (tgt_tick),
    .osc_tick_i (osc_tick_i),
    .done_o     (win_done),
    .err_o      (win_err)
  );

  lockdet_hyst #(
    .CNT_W        (CNT_W),
    .ASSERT_CNT   (ASSERT_CNT),
    .DEASSERT_CNT (DEASSERT_CNT)
  ) i_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (win_done),
    .err_i     (win_err),
    .lol_o     (lol_live),
    .lol_set_o (lol_set)
  );

  lockdet_sticky i_sticky (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (lol_set),
    .clr_i    (sticky_clr_i),
    .sticky_o (sticky_o),
    .clr_q_o  (clr_q)
  );

  assign acquire_o = lol_live;
  assign lol_o     = pin_sticky_i ? sticky_o : lol_live;

endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int unsigned CNT_W        = 18,
  parameter int unsigned ASSERT_CNT   = 100,
  parameter int unsigned DEASSERT_CNT = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             win_done_i,
  input logic [CNT_W-1:0] win_err_i,
  input logic             lol_live_i,
  input logic             pin_sticky_i,
  input logic             sticky_clr_i,
  input logic             lol_o,
  input logic             acquire_o,
  input logic             sticky_o
);

  localparam logic [CNT_W-1:0] HI = CNT_W'(ASSERT_CNT);
  localparam logic [CNT_W-1:0] LO = CNT_W'(DEASSERT_CNT);

  p_assert_band_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_i && win_err_i > HI) |=> lol_live_i);

  p_deassert_band_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_i && win_err_i <= LO) |=> !lol_live_i);

  p_hold_band_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_i && win_err_i > LO && win_err_i <= HI) |=> $stable(lol_live_i));

  p_only_on_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done_i |=> $stable(lol_live_i));

  p_sticky_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acquire_o) |-> sticky_o);

  p_sticky_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sticky_o) |-> ($past(sticky_clr_i, 2) && !$past(sticky_clr_i)));

  p_pin_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_sticky_i |-> (lol_o == sticky_o));

  p_acquire_live_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_sticky_i |-> (lol_o == acquire_o));

endmodule

bind freq_lock_detector lockdet_checker #(
  .CNT_W        (CNT_W),
  .ASSERT_CNT   (ASSERT_CNT),
  .DEASSERT_CNT (DEASSERT_CNT)
) i_lockdet_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_done_i   (win_done),
  .win_err_i    (win_err),
  .lol_live_i   (lol_live),
  .pin_sticky_i (pin_sticky_i),
  .sticky_clr_i (sticky_clr_i),
  .lol_o        (lol_o),
  .acquire_o    (acquire_o),
  .sticky_o     (sticky_o)
);

// File: tb/test_freq_lock_detector.sv
module test_freq_lock_detector;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 4000;
  localparam int A_CNT      = (WIN / 1000) * 1000 / 1000;
  localparam int D_CNT      = (WIN / 1000) * 250 / 1000;
  localparam int WDOG       = 190000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_tick_i = 1'b0, data_tick_i = 1'b0, ref_tick_i = 1'b0;
  logic ref_mode_i = 1'b0, pin_sticky_i = 1'b0, sticky_clr_i = 1'b0;
  logic lol_o, acquire_o, sticky_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  bit live_exp = 1'b1, sticky_exp = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  freq_lock_detector #(.WIN_TICKS(WIN)) i_freq_lock_detector (
    .clk_i, .rst_ni, .osc_tick_i, .data_tick_i, .ref_tick_i, .ref_mode_i,
    .pin_sticky_i, .sticky_clr_i, .lol_o, .acquire_o, .sticky_o
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Model: error band decision per closed window.
  task automatic model_window(int delta);
    int e;
    e = (delta < 0) ? -delta : delta;
    if (e > A_CNT) begin
      if (!live_exp) sticky_exp = 1'b1;
      live_exp = 1'b1;
    end else if (e <= D_CNT) begin
      live_exp = 1'b0;
    end
  endtask

  // Drives npairs target pulses on the selected input, two cycles each.
  // Base oscillator pulse shares the target cycle; extras follow it.
  task automatic drive_pairs(int delta, int npairs);
    for (int k = 0; k < npairs; k++) begin
      if (ref_mode_i) begin ref_tick_i = 1'b1; data_tick_i = 1'b1; end
      else            begin data_tick_i = 1'b1; ref_tick_i = 1'b1; end
      osc_tick_i = !(delta < 0 && k < -delta);
      step();
      if (ref_mode_i) begin ref_tick_i = 1'b0; data_tick_i = 1'b1; end
      else            begin data_tick_i = 1'b0; ref_tick_i = 1'b1; end
      osc_tick_i = (delta > 0 && k < delta);
      step();
    end
    osc_tick_i = 1'b0; data_tick_i = 1'b0; ref_tick_i = 1'b0;
    repeat (3) step();
  endtask

  task automatic window_and_check(string req, int delta);
    drive_pairs(delta, WIN);
    model_window(delta);
    chk({req, " lol_o"}, lol_o, pin_sticky_i ? sticky_exp : live_exp);
    chk({req, " acquire_o"}, acquire_o, live_exp);
    chk({req, " sticky_o"}, sticky_o, sticky_exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc >= WDOG && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 lol_o", lol_o, 1'b1);
    chk("R1 acquire_o", acquire_o, 1'b1);
    chk("R1 sticky_o", sticky_o, 1'b0);

    window_and_check("R4 err 3 while acquiring", 3);
    window_and_check("R3 err 1 locks", 1);
    window_and_check("R4 err +4 at assert edge", 4);
    window_and_check("R4 err -4 at assert edge", -4);
    window_and_check("R2 err -5 loses lock R8", -5);
    window_and_check("R8 err -1 relock sticky held", -1);

    // R10 pin mode: pin shows sticky while live is locked; R11 unaffected
    pin_sticky_i = 1'b1;
    step();
    chk("R10 lol_o sticky", lol_o, 1'b1);
    chk("R11 acquire_o live", acquire_o, 1'b0);

    // R9 held clear does nothing, falling edge clears
    sticky_clr_i = 1'b1;
    repeat (5) step();
    chk("R9 held clear", sticky_o, 1'b1);
    sticky_clr_i = 1'b0;
    step();
    sticky_exp = 1'b0;
    chk("R9 cleared sticky_o", sticky_o, 1'b0);
    chk("R10 lol_o after clear", lol_o, 1'b0);
    repeat (20) step();
    chk("R9 stays low", sticky_o, 1'b0);
    pin_sticky_i = 1'b0;

    // R6 reference mode, data input flooded
    ref_mode_i = 1'b1;
    repeat (2) step();
    window_and_check("R6 ref err +6 R2", 6);
    window_and_check("R6 ref err 0 R3", 0);

    // R7 partial window abandoned on mode change
    drive_pairs(WIN/4, WIN/4);
    chk("R5 partial window no effect", acquire_o, live_exp);
    ref_mode_i = 1'b0;
    repeat (2) step();
    window_and_check("R7 data err 0 after switch", 0);
    window_and_check("R5 data err 2 holds", 2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule